// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast system clock into the time base of a CAN node. A programmable divider produces a time-quantum tick. Each bit is then built from quanta in three consecutive parts: a one-quantum sync segment, time segment 1 (propagation plus first phase buffer) and time segment 2 (second phase buffer). Three single-cycle strobes mark the start of a bit, the point where the transmitter may drive the next bit, and the point where the bus is sampled.

All timing fields come from two configuration bytes, and each field is stored as its value minus one. While the bus is idle, a recessive-to-dominant transition restarts the bit immediately (hard synchronization). While a frame is in progress, such a transition moves the sample point instead: time segment 1 is stretched, or time segment 2 is cut short. The correction is limited by the synchronization jump width (SJW).

The sampled bit is offered as a valid-only stream: `sample_strobe` qualifies `sample_bit`. There is no ready input, because bus timing cannot be stalled. A consumer must take the bit within the bit time. All other pins are plain levels or single-cycle pulses.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` pulses for one clock every P+1 clocks, where P = `cfg_rate[5:0]`.
- R2: The sync segment lasts exactly one quantum. `tx_point` pulses on the tick that ends it, and time segment 1 starts with its first quantum.
- R3: Time segment 1 lasts `cfg_seg[3:0]`+1 quanta and time segment 2 lasts `cfg_seg[6:4]`+1 quanta, so a bit lasts 1 + TS1 + TS2 quanta. `cfg_seg[7]` has no effect on any output.
- R4: `sample_strobe` pulses on the tick that ends time segment 1. From the next clock, `sample_bit` holds the synchronized `rx` value seen in the strobe cycle. `bit_start`, `tx_point` and `sample_strobe` are never high together.
- R5: With `cfg_rate`=0x5F and `cfg_seg`=0x14 (prescaler 32, SJW 2, TS1 5, TS2 2), a bit is 8 quanta = 256 clocks, and the sample strobe comes 192 clocks after `bit_start`.
- R6: `rx` passes through two flip-flops. Only a 1-to-0 transition (recessive to dominant) counts as an edge. Rising transitions have no effect on timing.
- R7: When `bus_idle` is high and an edge is detected, `bit_start` pulses in that cycle, the prescaler restarts, and the bit restarts in the sync segment. The next `tx_point` follows P+1 clocks later.
- R8: An edge seen at the tick ending quantum q (0-based) of time segment 1 lengthens that segment by min(q+1, SJW) quanta, where SJW = `cfg_rate[7:6]`+1.
- R9: An edge seen at the tick ending quantum q of time segment 2 shortens that segment by min(TS2-1-q, SJW) quanta. If this uses up the remaining quanta, the bit ends at that tick.
- R10: At most one correction is applied between two sample strobes, and after a hard synchronization no correction is applied until the next sample strobe. An edge that falls in the sync segment causes no correction.
- R11: During reset all strobes are low and `sample_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 8 | [7:6] SJW-1, [5:0] prescaler-1 |
| cfg_seg | input | 8 | [6:4] TS2-1, [3:0] TS1-1, [7] unused |
| bus_idle | input | 1 | High while no frame is in progress; enables hard synchronization |
| rx | input | 1 | Raw bus level, 0 = dominant |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| bit_start | output | 1 | Pulse as a new bit (sync segment) begins |
| tx_point | output | 1 | Pulse at the end of the sync segment |
| sample_strobe | output | 1 | Pulse at the sample point; qualifies `sample_bit` |
| sample_bit | output | 1 | Bus level captured at the last sample point |

## Verification
A quiet bus with a fixed configuration shows the nominal quantum, bit and sample spacing. Single falling edges are placed at chosen quanta: inside the sync segment, early and late in segment 1, and early and late in segment 2. These separate the lengthening path, the shortening path with its SJW clamp, and the ignored sync-segment case. A pair of edges in one segment 1 shows that only one correction is applied between sample points. Long runs of pseudo-random toggles, with the bus idle and with a frame in progress, are compared clock by clock with a behavioural model, so that hard and soft synchronization are exercised at every phase.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] div_m1,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q >= div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div_m1 != '0) |=> (!tick || div_m1 != $past(div_m1))); // R1
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic tick,
  input  logic restart,
  output logic rx_sync,
  output logic fall,
  output logic edge_seen
);
  logic s1_q, s2_q, pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx;
      s2_q <= s1_q;
    end
  end

  assign rx_sync   = s1_q;
  assign fall      = s2_q & ~s1_q;
  assign edge_seen = pend_q | fall;

  always_ff @(posedge clk) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (restart || tick)  pend_q <= 1'b0;
    else if (fall)             pend_q <= 1'b1;
  end

  AST_FALL_FROM_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !$past(rx)); // R6
  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick || restart) |=> !pend_q); // R10
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hard_sync,
  input  logic             edge_seen,
  input  logic             rx_sync,
  input  logic [SJW_W-1:0] sjw_m1,
  input  logic [TS1_W-1:0] ts1_m1,
  input  logic [TS2_W-1:0] ts2_m1,
  output logic             bit_start,
  output logic             tx_point,
  output logic             sample_strobe,
  output logic             sample_bit
);
  localparam int WMAX = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int QW   = ((WMAX > SJW_W) ? WMAX : SJW_W) + 2;

  seg_e          seg_q, seg_d;
  logic [QW-1:0] q_q, q_d, adj_q, adj_d;
  logic          allow_q, allow_d, sbit_q;
  logic [QW-1:0] ts1_v, ts2_v, sjw_v, err, lim, step;
  logic          resync;

  assign ts1_v  = QW'(ts1_m1);
  assign ts2_v  = QW'(ts2_m1);
  assign sjw_v  = QW'(sjw_m1) + QW'(1);
  assign resync = edge_seen & allow_q;

  always_comb begin
    seg_d         = seg_q;
    q_d           = q_q;
    adj_d         = adj_q;
    allow_d       = allow_q;
    bit_start     = 1'b0;
    tx_point      = 1'b0;
    sample_strobe = 1'b0;
    err           = '0;
    lim           = '0;
    step          = adj_q;
    if (hard_sync) begin
      seg_d     = SEG_SYNC;
      q_d       = '0;
      adj_d     = '0;
      allow_d   = 1'b0;
      bit_start = 1'b1;
    end else if (tick) begin
      case (seg_q)
        SEG_SYNC: begin
          seg_d    = SEG_TS1;
          q_d      = '0;
          adj_d    = '0;
          tx_point = 1'b1;
        end
        SEG_TS1: begin
          if (resync) begin
            err     = q_q + QW'(1);
            step    = (err < sjw_v) ? err : sjw_v;
            allow_d = 1'b0;
          end
          adj_d = step;
          lim   = ts1_v + step;
          if (q_q >= lim) begin
            seg_d         = SEG_TS2;
            q_d           = '0;
            adj_d         = '0;
            allow_d       = 1'b1;
            sample_strobe = 1'b1;
          end else begin
            q_d = q_q + QW'(1);
          end
        end
        SEG_TS2: begin
          if (resync) begin
            err     = (q_q >= ts2_v) ? '0 : (ts2_v - q_q);
            step    = (err < sjw_v) ? err : sjw_v;
            allow_d = 1'b0;
          end
          adj_d = step;
          lim   = (step >= ts2_v) ? '0 : (ts2_v - step);
          if (q_q >= lim) begin
            seg_d     = SEG_SYNC;
            q_d       = '0;
            adj_d     = '0;
            bit_start = 1'b1;
          end else begin
            q_d = q_q + QW'(1);
          end
        end
        default: begin
          seg_d = SEG_SYNC;
          q_d   = '0;
          adj_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q   <= SEG_SYNC;
      q_q     <= '0;
      adj_q   <= '0;
      allow_q <= 1'b1;
      sbit_q  <= 1'b1;
    end else begin
      seg_q   <= seg_d;
      q_q     <= q_d;
      adj_q   <= adj_d;
      allow_q <= allow_d;
      if (sample_strobe) sbit_q <= rx_sync;
    end
  end

  assign sample_bit = sbit_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_start, tx_point, sample_strobe})); // R4
  AST_SYNC_ONE_TQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point |=> (seg_q == SEG_TS1 && q_q == '0)); // R2
  AST_SAMPLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> (seg_q == SEG_TS2 && sample_bit == $past(rx_sync))); // R4
  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hard_sync |=> (seg_q == SEG_SYNC && q_q == '0 && !allow_q)); // R7
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(allow_q) |-> $past(sample_strobe)); // R10
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SJW_W+BRP_W-1:0] cfg_rate,
  input  logic [TS2_W+TS1_W:0]   cfg_seg,
  input  logic                   bus_idle,
  input  logic                   rx,
  output logic                   tq_tick,
  output logic                   bit_start,
  output logic                   tx_point,
  output logic                   sample_strobe,
  output logic                   sample_bit
);
  logic [BRP_W-1:0] brp_m1;
  logic [SJW_W-1:0] sjw_m1;
  logic [TS1_W-1:0] ts1_m1;
  logic [TS2_W-1:0] ts2_m1;
  logic rx_sync, fall, edge_seen, hard_sync;

  assign brp_m1    = cfg_rate[BRP_W-1:0];
  assign sjw_m1    = cfg_rate[SJW_W+BRP_W-1:BRP_W];
  assign ts1_m1    = cfg_seg[TS1_W-1:0];
  assign ts2_m1    = cfg_seg[TS2_W+TS1_W-1:TS1_W];
  assign hard_sync = bus_idle & fall;

  can_bt_prescaler #(.W(BRP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(hard_sync), .div_m1(brp_m1), .tick(tq_tick)
  );

  can_bt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tq_tick), .restart(hard_sync),
    .rx_sync(rx_sync), .fall(fall), .edge_seen(edge_seen)
  );

  can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .hard_sync(hard_sync),
    .edge_seen(edge_seen), .rx_sync(rx_sync), .sjw_m1(sjw_m1),
    .ts1_m1(ts1_m1), .ts2_m1(ts2_m1), .bit_start(bit_start),
    .tx_point(tx_point), .sample_strobe(sample_strobe), .sample_bit(sample_bit)
  );
endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_rate = 8'h5F;
  logic [7:0] cfg_seg = 8'h14;
  logic bus_idle = 1'b1;
  logic rx = 1'b1;
  logic tq_tick, bit_start, tx_point, sample_strobe, sample_bit;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string phase = "R11";

  always #10 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_seg(cfg_seg),
    .bus_idle(bus_idle), .rx(rx), .tq_tick(tq_tick), .bit_start(bit_start),
    .tx_point(tx_point), .sample_strobe(sample_strobe), .sample_bit(sample_bit)
  );

  // behavioural reference state
  int m_s1, m_s2, m_pre, m_seg, m_q, m_adj, m_pend, m_allow, m_sbit;
  bit e_tick, e_bs, e_txp, e_smp;

  task automatic model(input bit commit);
    int brp, sjw, ts1, ts2, lim;
    int n_seg, n_q, n_adj, n_allow, n_sbit;
    bit fall, tick, hs, rs;
    brp = int'(cfg_rate[5:0]) + 1;
    sjw = int'(cfg_rate[7:6]) + 1;
    ts1 = int'(cfg_seg[3:0]) + 1;
    ts2 = int'(cfg_seg[6:4]) + 1;
    fall = (m_s2 == 1) && (m_s1 == 0);
    tick = m_pre >= brp - 1;
    hs = bus_idle && fall;
    rs = (m_pend == 1 || fall) && m_allow == 1;
    n_seg = m_seg; n_q = m_q; n_adj = m_adj; n_allow = m_allow; n_sbit = m_sbit;
    e_tick = tick; e_bs = 0; e_txp = 0; e_smp = 0;
    if (hs) begin
      n_seg = 0; n_q = 0; n_adj = 0; n_allow = 0; e_bs = 1;
    end else if (tick) begin
      if (m_seg == 0) begin
        n_seg = 1; n_q = 0; n_adj = 0; e_txp = 1;
      end else if (m_seg == 1) begin
        if (rs) begin n_adj = (m_q + 1 < sjw) ? m_q + 1 : sjw; n_allow = 0; end
        lim = ts1 - 1 + n_adj;
        if (m_q >= lim) begin
          n_seg = 2; n_q = 0; n_adj = 0; n_allow = 1; e_smp = 1; n_sbit = m_s1;
        end else n_q = m_q + 1;
      end else begin
        if (rs) begin
          lim = (m_q >= ts2 - 1) ? 0 : ts2 - 1 - m_q;
          n_adj = (lim < sjw) ? lim : sjw; n_allow = 0;
        end
        lim = ts2 - 1 - n_adj;
        if (m_q >= lim) begin n_seg = 0; n_q = 0; n_adj = 0; e_bs = 1; end
        else n_q = m_q + 1;
      end
    end
    if (commit) begin
      m_pend = (hs || tick) ? 0 : ((m_pend == 1 || fall) ? 1 : 0);
      m_pre = (hs || tick) ? 0 : m_pre + 1;
      m_seg = n_seg; m_q = n_q; m_adj = n_adj; m_allow = n_allow; m_sbit = n_sbit;
      m_s2 = m_s1; m_s1 = int'(rx);
    end
  endtask

  task automatic model_reset();
    m_s1 = 1; m_s2 = 1; m_pre = 0; m_seg = 0; m_q = 0; m_adj = 0;
    m_pend = 0; m_allow = 1; m_sbit = 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model(1'b1);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    model(1'b0);
    tests++;
    if (tq_tick !== e_tick || bit_start !== e_bs || tx_point !== e_txp ||
        sample_strobe !== e_smp || sample_bit !== m_sbit[0]) begin
      fails++;
      $display("FAIL %s model (tick R1, bs R7, tx R2, smp R4): actual %b%b%b%b%b expected %b%b%b%b%b",
               phase, tq_tick, bit_start, tx_point, sample_strobe, sample_bit,
               e_tick, e_bs, e_txp, e_smp, m_sbit[0]);
    end
  end

  task automatic wait_bs();
    do @(negedge clk); while (!bit_start);
  endtask

  task automatic gap_to_bs(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_start);
  endtask

  // edges at chosen clock offsets after a bit start; returns the bit length
  task automatic edge_probe(input int n1, input int n2, output int len);
    int c = 0;
    wait_bs();
    while (1) begin
      @(posedge clk); c++; #1;
      if (c == n1) rx = 1'b0;
      if (c == n1 + 2) rx = 1'b1;
      if (n2 > 0 && c == n2) rx = 1'b0;
      if (n2 > 0 && c == n2 + 2) rx = 1'b1;
      @(negedge clk);
      if (bit_start) break;
    end
    rx = 1'b1;
    len = c;
  endtask

  task automatic random_run(input int cycles, input bit idle);
    int lf = 32'h1D3A;
    bus_idle = idle;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      if ((lf & 15) == 0) rx = ~rx;
    end
    rx = 1'b1;
  endtask

  initial begin
    int n;
    // R11: reset state
    repeat (4) @(negedge clk);
    check("R11", "tq_tick", tq_tick, 0);
    check("R11", "strobes", {bit_start, tx_point, sample_strobe}, 0);
    check("R11", "sample_bit", sample_bit, 1);
    @(posedge clk); #1; rst_n = 1'b1; bus_idle = 1'b0;

    // R5 / R1: nominal timing with 0x5F / 0x14
    phase = "R5";
    wait_bs();
    gap_to_bs(n); check("R5", "bit clocks", n, 256);
    n = 0; do begin @(negedge clk); n++; end while (!sample_strobe);
    check("R5", "sample offset", n, 192);
    n = 0; do begin @(negedge clk); n++; end while (!tq_tick);
    check("R1", "quantum clocks", n, 32);
    n = 0; do begin @(negedge clk); n++; end while (!tq_tick);
    check("R1", "quantum clocks again", n, 32);

    // R3: bit 7 of the segment byte has no effect
    phase = "R3";
    cfg_seg = 8'h94;
    wait_bs(); wait_bs();
    gap_to_bs(n); check("R3", "bit clocks with bit7 set", n, 256);

    // small configuration: prescaler 4, SJW 2, TS1 5, TS2 3 -> 36 clocks per bit
    cfg_rate = 8'h43; cfg_seg = 8'h24;
    wait_bs(); wait_bs();
    gap_to_bs(n); check("R3", "bit clocks 9 quanta", n, 36);

    // R7: hard synchronization while idle
    phase = "R7";
    bus_idle = 1'b1;
    repeat (7) @(posedge clk); #1; rx = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7", "bit_start on idle edge", bit_start, 1);
    repeat (4) @(negedge clk);
    check("R2", "tx_point one quantum later", tx_point, 1);
    @(posedge clk); #1; rx = 1'b1;
    @(posedge clk); #1; rx = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7", "bit_start on second idle edge", bit_start, 1);
    @(posedge clk); #1; rx = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6", "rising edge no bit_start", bit_start, 0);
    bus_idle = 1'b0;
    wait_bs(); wait_bs();

    // R8: edge in segment 1, clamp to SJW 2
    phase = "R8";
    edge_probe(12, 0, n); check("R8", "lengthened bit", n, 44);
    edge_probe(5, 0, n);  check("R8", "edge in TS1 q0 lengthens by 1", n, 40);
    // R9: edge in segment 2
    phase = "R9";
    edge_probe(25, 0, n); check("R9", "shortened bit clamp", n, 28);
    edge_probe(29, 0, n); check("R9", "shortened by 1", n, 32);
    // R10: sync-segment edge and double edge
    phase = "R10";
    edge_probe(1, 0, n);   check("R10", "edge in sync seg", n, 36);
    edge_probe(12, 18, n); check("R10", "second edge ignored", n, 44);
    edge_probe(0, 0, n);   check("R10", "quiet bit", n, 36);

    // R4: sampled level follows the bus
    phase = "R4";
    rx = 1'b0;
    do @(negedge clk); while (!sample_strobe);
    @(negedge clk); check("R4", "sample_bit dominant", sample_bit, 0);
    rx = 1'b1;
    do @(negedge clk); while (!sample_strobe);
    @(negedge clk); check("R4", "sample_bit recessive", sample_bit, 1);

    // random traffic against the model
    phase = "R6";  random_run(3000, 1'b0);
    phase = "R9";  cfg_rate = 8'hC2; cfg_seg = 8'h37; random_run(3000, 1'b0);
    phase = "R7";  random_run(2000, 1'b1);
    phase = "R8";  cfg_rate = 8'h80; cfg_seg = 8'h70; random_run(2000, 1'b0);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule